// File: doc/BRIEF.md
# NAND Flash Controller Register Front End

This block sits between a 32-bit memory-mapped register bus and the command sequencer of a NAND flash controller. It decodes three registers: a control register, which holds the run bit and twelve per-event interrupt masks, a status register of twelve flags, and a command port. It turns three successive writes to the command port into one three-word command, which it hands to the sequencer.

The sequencer reports events to the block as single-cycle pulses. The block latches these pulses into sticky flags, which software clears by writing ones. The flash ready/busy line appears live in the top status bit. A single interrupt output is raised whenever a set flag has its mask bit at zero.

Software first sets the run bit, which raises the write-command-request flag. It then writes the three command words to the same offset. The block presents the three words on a one-cycle `cmd_valid_o` pulse. Clearing the run bit abandons a partly loaded command.

Top module: `nfc_reg_front`

## Requirements
- R1: After reset, the control register at offset 0x00 reads 0x00000FFF, the status register at offset 0x14 reads zero apart from bit 11, and `irq_o` and `cmd_valid_o` are low. A write to 0x00 stores the full 32-bit word, and a read returns that word.
- R2: Status bit 11 reads the current level of `rdy_i`, and a write of one to that bit has no effect on it.
- R3: A pulse on `evt_i[k]` sets status bit k+1 for k from 0 to 9. The bit stays set until it is cleared by software, and writing 0 to it leaves it unchanged.
- R4: Writing a 1 to status bit n (offset 0x14) clears that flag.
- R5: When an event pulse and a write of one to the same status bit fall in the same cycle, the bit is left set.
- R6: Bits 11:0 of the control register are interrupt masks aligned with the status bits, where 1 disables an event. `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R7: A write to the control register that changes bit 28 (the run bit) from 0 to 1 sets status bit 0, the write-command request. `run_o` follows bit 28.
- R8: A write to offset 0x48 is ignored unless the run bit and status bit 0 are both set. An ignored write produces no command and does not advance the word count.
- R9: Accepted writes to 0x48 fill words 0, 1 and 2 in turn. In the cycle after the third accepted write, `cmd_valid_o` is high for one cycle, carrying all three words, and status bit 0 reads 0.
- R10: Clearing the run bit clears status bit 0 and discards any partly loaded command. The next command after the run bit is set again starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_i | input | 10 | Event pulses from the sequencer; bit k sets status bit k+1 |
| rdy_i | input | 1 | Flash ready/busy level |
| run_o | output | 1 | Run bit to the sequencer |
| cmd_valid_o | output | 1 | One-cycle pulse when a command is complete |
| cmd_word0_o | output | 32 | Command word 0 |
| cmd_word1_o | output | 32 | Command word 1 |
| cmd_word2_o | output | 32 | Command word 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act on the same status bit in the same cycle: the sticky set from a sequencer event, and the clear that software performs by writing ones. The stimulus table raises an event pulse in exactly the cycle that a write of one to the status offset targets the same bit. The bench then reads the register back and expects the bit to remain set, while a bit cleared in the same write with no event is expected to drop. A second collision lies on the write-command request: the third command word clears it in the very edge that publishes the command. The bench reads it back as zero while `cmd_valid_o` is still high.

// File: rtl/nfc_regs_pkg.sv
package nfc_regs_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STAT_W    = 12;
  localparam int unsigned EVT_W     = STAT_W - 2;
  localparam int unsigned CMD_WORDS = 3;
  localparam int unsigned RUN_BIT   = 28;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h48;

  localparam logic [DATA_W-1:0] CTRL_RST = {{(DATA_W-STAT_W){1'b0}}, {STAT_W{1'b1}}};
endpackage

// File: rtl/nfc_ctrl_reg.sv
module nfc_ctrl_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STAT_W  = 12,
  parameter int unsigned RUN_BIT = 28,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              run_o,
  output logic              run_rise_o
);
  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= RST_VAL;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o     = ctrl_q;
  assign mask_o     = ctrl_q[STAT_W-1:0];
  assign run_o      = ctrl_q[RUN_BIT];
  assign run_rise_o = we_i & wdata_i[RUN_BIT] & ~ctrl_q[RUN_BIT];

  p_run_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_rise_o |=> run_o);
endmodule

// File: rtl/nfc_stat_bank.sv
module nfc_stat_bank #(
  parameter int unsigned STAT_W = 12,
  parameter int unsigned EVT_W  = STAT_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              wcr_set_i,
  input  logic              wcr_clr_i,
  input  logic              rdy_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [EVT_W:1] ev_q;
  logic           wcr_q;

  for (genvar g = 1; g <= EVT_W; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    ev_q[g] <= 1'b0;
      else if (evt_i[g-1])            ev_q[g] <= 1'b1; // event beats clear
      else if (clr_we_i && clr_i[g])  ev_q[g] <= 1'b0;
    end

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q[g] && !(clr_we_i && clr_i[g])) |=> ev_q[g]);
    p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g-1] |=> stat_o[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   wcr_q <= 1'b0;
    else if (wcr_set_i)                            wcr_q <= 1'b1;
    else if (wcr_clr_i || (clr_we_i && clr_i[0]))  wcr_q <= 1'b0;
  end

  assign stat_o = {rdy_i, ev_q, wcr_q};
  assign irq_o  = |(stat_o & ~mask_i);

  p_wcr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcr_set_i |=> stat_o[0]);
  p_mask_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);
endmodule

// File: rtl/nfc_cmd_loader.sv
module nfc_cmd_loader #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CMD_WORDS = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic                            accept_i,
  input  logic                            abort_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [CMD_WORDS-1:0][DATA_W-1:0] words_o,
  output logic                            valid_o,
  output logic                            last_o
);
  localparam int unsigned CNT_W = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;
  logic             valid_q;
  logic [CMD_WORDS-1:0][DATA_W-1:0] words_q;

  assign take   = we_i & accept_i;
  assign last_o = take & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (abort_i) cnt_q <= '0;
    else if (take)    cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= last_o;
  end

  for (genvar w = 0; w < CMD_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               words_q[w] <= '0;
      else if (take && cnt_q == CNT_W'(w))       words_q[w] <= wdata_i;
    end
  end

  assign words_o = words_q;
  assign valid_o = valid_q;

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !accept_i && !abort_i) |=> $stable(cnt_q));
  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cnt_q == '0 && !valid_o));
endmodule

// File: rtl/nfc_reg_front.sv
module nfc_reg_front
  import nfc_regs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = STAT_W,
  parameter int unsigned EW = EVT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [EW-1:0] evt_i,
  input  logic          rdy_i,
  output logic          run_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_word0_o,
  output logic [DW-1:0] cmd_word1_o,
  output logic [DW-1:0] cmd_word2_o,
  output logic          irq_o
);
  logic          we_ctrl, we_stat, we_cmd;
  logic [DW-1:0] ctrl;
  logic [SW-1:0] mask, stat;
  logic          run, run_rise, last;
  logic [CMD_WORDS-1:0][DW-1:0] words;

  assign we_ctrl = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign we_stat = reg_we_i && (reg_addr_i == OFF_STAT);
  assign we_cmd  = reg_we_i && (reg_addr_i == OFF_CMD);

  nfc_ctrl_reg #(.DATA_W(DW), .STAT_W(SW), .RUN_BIT(RUN_BIT), .RST_VAL(CTRL_RST)) u_ctrl (
    .clk_i, .rst_ni, .we_i(we_ctrl), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .mask_o(mask), .run_o(run), .run_rise_o(run_rise)
  );

  nfc_stat_bank #(.STAT_W(SW), .EVT_W(EW)) u_stat (
    .clk_i, .rst_ni, .evt_i, .clr_we_i(we_stat), .clr_i(reg_wdata_i[SW-1:0]),
    .wcr_set_i(run_rise), .wcr_clr_i(last | ~run), .rdy_i, .mask_i(mask),
    .stat_o(stat), .irq_o
  );

  nfc_cmd_loader #(.DATA_W(DW), .CMD_WORDS(CMD_WORDS)) u_cmd (
    .clk_i, .rst_ni, .we_i(we_cmd), .accept_i(run & stat[0]), .abort_i(~run),
    .wdata_i(reg_wdata_i), .words_o(words), .valid_o(cmd_valid_o), .last_o(last)
  );

  always_comb begin
    case (reg_addr_i)
      OFF_CTRL: reg_rdata_o = ctrl;
      OFF_STAT: reg_rdata_o = {{(DW-SW){1'b0}}, stat};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign run_o       = run;
  assign cmd_word0_o = words[0];
  assign cmd_word1_o = words[1];
  assign cmd_word2_o = words[2];

  p_wcr_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !stat[0]);
  p_no_valid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> !cmd_valid_o);
endmodule

// File: tb/sim_nfc_reg_front.sv
module sim_nfc_reg_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        rdy = 1'b0;
  logic        run, vld, irq;
  logic [31:0] w0, w1, w2;

  int checks = 0, fails = 0, vcount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nfc_reg_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .rdy_i(rdy),
    .run_o(run), .cmd_valid_o(vld), .cmd_word0_o(w0), .cmd_word1_o(w1),
    .cmd_word2_o(w2), .irq_o(irq)
  );

  always @(posedge clk) if (vld) vcount++;

  // evt[33:24] clr[23:12] expected status[11:0]; mask 0xFE7, rdy low
  localparam logic [33:0] TBL [0:8] = '{
    {10'h080, 12'h000, 12'h100},
    {10'h004, 12'h000, 12'h108},
    {10'h000, 12'h100, 12'h008},
    {10'h008, 12'h008, 12'h010},
    {10'h008, 12'h010, 12'h010},
    {10'h000, 12'h000, 12'h010},
    {10'h000, 12'h010, 12'h000},
    {10'h3FF, 12'h000, 12'h7FE},
    {10'h000, 12'hFFF, 12'h000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    int v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl reset", r, 32'h0000_0FFF);
    rd(8'h14, r); chk("R1 stat reset", r, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 valid reset", {31'b0, vld}, 32'h0);
    wr(8'h00, 32'h0000_0FE7);
    rd(8'h00, r); chk("R1 ctrl readback", r, 32'h0000_0FE7);

    // table: events, W1C, same-cycle collision (R3 R4 R5 R6)
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      evt = TBL[i][33:24];
      if (TBL[i][23:12] != 12'h0) begin we = 1'b1; addr = 8'h14; wdata = {20'b0, TBL[i][23:12]}; end
      @(negedge clk); evt = '0; we = 1'b0;
      rd(8'h14, r);
      chk($sformatf("R3/R4/R5 table %0d stat", i), r, {20'b0, TBL[i][11:0]});
      chk($sformatf("R6 table %0d irq", i), {31'b0, irq}, {31'b0, |(TBL[i][11:0] & ~12'hFE7)});
    end

    // R6 mask polarity
    @(negedge clk); evt = 10'h020; @(negedge clk); evt = '0;
    #1 chk("R6 masked event no irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0000_0FA7);
    #1 chk("R6 unmasked event irq", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0000_0040);
    #1 chk("R6 cleared irq", {31'b0, irq}, 32'h0);

    // R2 ready level, W1C no effect
    rdy = 1'b1;
    rd(8'h14, r); chk("R2 ready bit", r, 32'h800);
    wr(8'h14, 32'h0000_0800);
    rd(8'h14, r); chk("R2 w1c ignored", r, 32'h800);
    wr(8'h00, 32'h0000_07FF);
    #1 chk("R6 ready irq", {31'b0, irq}, 32'h1);
    rdy = 1'b0;
    #1 chk("R2 ready drop irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0000_0FFF);

    // R8 command writes before run are ignored
    v0 = vcount;
    wr(8'h48, 32'hDEAD_0001); wr(8'h48, 32'hDEAD_0002); wr(8'h48, 32'hDEAD_0003);
    @(negedge clk);
    chk("R8 no cmd before run", vcount - v0, 0);

    // R7 run rise raises request
    wr(8'h00, 32'h1000_0FFF);
    chk("R7 run_o", {31'b0, run}, 32'h1);
    rd(8'h14, r); chk("R7 request set", r, 32'h001);

    // R9 load three words
    v0 = vcount;
    wr(8'h48, 32'hA000_0000);
    wr(8'h48, 32'hB000_0001);
    #1 chk("R9 no early valid", {31'b0, vld}, 32'h0);
    wr(8'h48, 32'hC000_0002);
    #1 chk("R9 valid pulse", {31'b0, vld}, 32'h1);
    chk("R9 word0", w0, 32'hA000_0000);
    chk("R9 word1", w1, 32'hB000_0001);
    chk("R9 word2", w2, 32'hC000_0002);
    addr = 8'h14; #1 chk("R9 request cleared", rdata, 32'h0);
    @(negedge clk);
    chk("R9 single pulse", vcount - v0, 1);

    // R8 write after load ignored (request low)
    wr(8'h48, 32'h1111_1111);
    @(negedge clk);
    chk("R8 post-load ignored", vcount - v0, 1);
    chk("R8 word0 kept", w0, 32'hA000_0000);

    // R10 abort discards partial load
    wr(8'h00, 32'h0000_0FFF);
    wr(8'h00, 32'h1000_0FFF);
    wr(8'h48, 32'h2222_2222);
    wr(8'h48, 32'h3333_3333);
    wr(8'h00, 32'h0000_0FFF);
    rd(8'h14, r); chk("R10 request cleared by stop", r, 32'h0);
    wr(8'h00, 32'h1000_0FFF);
    v0 = vcount;
    wr(8'h48, 32'hD000_0000);
    wr(8'h48, 32'hE000_0001);
    wr(8'h48, 32'hF000_0002);
    #1 chk("R10 valid after restart", {31'b0, vld}, 32'h1);
    chk("R10 word0 fresh", w0, 32'hD000_0000);
    chk("R10 word1 fresh", w1, 32'hE000_0001);
    chk("R10 word2 fresh", w2, 32'hF000_0002);
    @(negedge clk);
    chk("R10 one command", vcount - v0, 1);

    done = 1;
    finish_run();
  end
endmodule